// File: doc/BRIEF.md
# Width-Limited In-Order Retire Stage

This block is the retire loop that sits behind a reorder buffer in an out-of-order core. Every cycle it looks at a window of the oldest buffer entries, starting at the head, and decides how many of them leave the buffer. Normal completed entries are committed, up to a fixed commit width. Entries already marked squashed are dropped for free. Entries that need special treatment stop the scan. These are unexecuted serialising operations, unexecuted loads that must go out uncached, and faulting operations. They may act only when they would be the first commit of the cycle and the store path has nothing left to write back.

The retire and commit strobes are combinational, so the buffer pops its head entries at the same edge. The occupancy input is the count before this cycle's insertions, which makes retirement logically come ahead of new entries from rename. The feedback outputs are as follows:
- the sequence number of the youngest committed entry;
- a serialising request that carries a sequence number, with an uncached-load qualifier; the request also tells the buffer to clear that entry's can-commit flag;
- a strobe that says the entry count changed;
- an empty indication for the earlier stages.

A fault moves the unit into a trap-pending state. Retirement stays held in that state until the trap logic outside this block acknowledges it. Two free-running counters record retire bandwidth:
- the number of cycles that used the full width;
- a histogram of commits per cycle.

Top module: `commit_retire_unit`

## Requirements
- R1: The scan walks window entries from index 0 (the head) upward. It stops at the first entry that is not valid or not ready, or once WIDTH entries have been committed. No entry after the stop point gets a retire or commit strobe, and the retire mask is always a contiguous run from index 0.
- R2: A valid, ready entry marked squashed raises its retire strobe but not its commit strobe. It does not count toward WIDTH, and the scan continues past it.
- R3: A valid, ready, executed, fault-free entry commits: it raises both its retire and commit strobes. `done_valid` goes high and `done_seq` carries the sequence number of the highest-index entry committed in that cycle.
- R4: An unexecuted entry with the serialising flag acts only when no entry has committed earlier in the cycle (squashed drops do not count) and `stores_pending` is low. When it acts, it raises `ns_req` with its sequence number on `ns_seq` and `ns_uncached` low. In every case it is not retired and the scan stops.
- R5: An unexecuted entry with the load flag but no serialising flag follows the same first-commit and no-pending-store condition. When the condition holds, it raises `ns_req` and `ns_uncached` together with its sequence number. It is not retired and the scan stops.
- R6: An executed entry with the fault flag also needs the first-commit and no-pending-store condition. When it holds, `trap_pending` goes high from the next cycle. The entry is not retired and the scan stops. While `trap_pending` is high, no entry retires. A `trap_resolve` pulse clears `trap_pending` at the next edge.
- R7: An unexecuted entry that is neither serialising nor a load stops the scan. It produces no retirement and no feedback.
- R8: `entries_changed` is high in exactly the cycles in which at least one entry retires.
- R9: The empty indication arms in two ways: at reset, and in any cycle where retirement leaves the occupancy minus the retire count at zero. It stays armed while that remaining count is zero. `rob_empty_ind` pulses once, and disarms, in the first armed cycle with a remaining count of zero, `stores_pending` low and no store-flagged entry committed in the same cycle.
- R10: `full_width_cycles` increments by one after every cycle in which exactly WIDTH entries committed, and holds otherwise.
- R11: Bin k of `commit_hist` (bits k*CNT_W upward) increments after every cycle in which exactly k entries committed, for k from 0 to WIDTH.
- R12: Synchronous active-low reset clears `trap_pending`, both counters and all histogram bins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_valid | input | WINDOW | Window entry holds an instruction |
| ent_ready | input | WINDOW | Entry's can-commit flag |
| ent_executed | input | WINDOW | Entry has executed |
| ent_squashed | input | WINDOW | Entry was squashed |
| ent_nonspec | input | WINDOW | Serialising: non-speculative, store-conditional or barrier |
| ent_load | input | WINDOW | Entry is a load |
| ent_store | input | WINDOW | Entry is a store |
| ent_fault | input | WINDOW | Entry raised a fault |
| ent_seq | input | WINDOW*SEQ_W | Sequence numbers, entry i at bits i*SEQ_W upward |
| stores_pending | input | 1 | Store path still has writebacks outstanding |
| rob_occupancy | input | OCC_W | Buffer entry count before this cycle's insertions |
| trap_resolve | input | 1 | Trap logic has taken the pending trap |
| retire_mask | output | WINDOW | Entries leaving the buffer this cycle |
| commit_mask | output | WINDOW | Entries committed this cycle |
| done_valid | output | 1 | At least one commit this cycle |
| done_seq | output | SEQ_W | Youngest committed sequence number |
| ns_req | output | 1 | Serialising or uncached request; clear that entry's can-commit flag |
| ns_uncached | output | 1 | Request is an uncached load |
| ns_seq | output | SEQ_W | Sequence number of the requesting entry |
| trap_pending | output | 1 | Fault taken, retirement held |
| entries_changed | output | 1 | Free-entry count changed this cycle |
| rob_empty_ind | output | 1 | Empty indication to earlier stages |
| full_width_cycles | output | CNT_W | Cycles with WIDTH commits |
| commit_hist | output | (WIDTH+1)*CNT_W | Commits-per-cycle histogram |

## Verification
The bench builds the unit with WIDTH 2 and a window of 4 entries. Each entry then takes one of nine attribute classes: absent, not ready, squashed, plain commit, store commit, serialising, load, faulting, and other unexecuted. The stores-pending input is swept with them, so every ordering of 6561 class patterns is applied under both store states. This covers several cases:
- squashed drops interleaved with commits, including drops that push the scan past the width;
- special entries in first and non-first position;
- every stop point.

Directed sequences after reset exercise arming and withholding of the empty indication. Every fault raised in the sweep is followed by a held cycle and an acknowledge. The counters are compared at the end against totals accumulated over all cycles.

// File: rtl/commit_retire_pkg.sv
// Shared types for the retire stage.
package commit_retire_pkg;

    // What one window entry does in the current cycle.
    typedef enum logic [2:0] {
        ACT_STOP     = 3'd0,   // scan ends here, nothing leaves
        ACT_DROP     = 3'd1,   // squashed entry leaves for free
        ACT_COMMIT   = 3'd2,   // normal commit
        ACT_NONSPEC  = 3'd3,   // serialising request sent, scan ends
        ACT_UNCACHED = 3'd4,   // uncached load request sent, scan ends
        ACT_FAULT    = 3'd5    // fault taken, scan ends
    } slot_act_t;

endpackage

// File: rtl/commit_slot.sv
// One link of the retire scan chain.
// Decides the action of a single window entry from its attributes, the
// number of commits already made earlier in the cycle and the store state.
// Assumes the chain is evaluated head first and go_in is low once any
// earlier link has stopped.
module commit_slot
    import commit_retire_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic          go_in,
    input  logic [CW-1:0] cnt_in,
    input  logic          valid,
    input  logic          ready,
    input  logic          executed,
    input  logic          squashed,
    input  logic          nonspec,
    input  logic          is_load,
    input  logic          fault,
    input  logic          stores_pending,
    output logic          go_out,
    output logic [CW-1:0] cnt_out,
    output slot_act_t     act
);

    logic first_ok;

    // Special entries may act only as the first commit with no stores owed.
    assign first_ok = (cnt_in == '0) && !stores_pending;

    // Classify this entry and propagate the chain state.
    always_comb begin
        act     = ACT_STOP;
        go_out  = 1'b0;
        cnt_out = cnt_in;
        if (go_in && (cnt_in != CW'(WIDTH)) && valid && ready) begin
            if (squashed) begin
                act    = ACT_DROP;
                go_out = 1'b1;
            end else if (!executed) begin
                if (nonspec)
                    act = first_ok ? ACT_NONSPEC : ACT_STOP;
                else if (is_load)
                    act = first_ok ? ACT_UNCACHED : ACT_STOP;
                else
                    act = ACT_STOP;
            end else if (fault) begin
                act = first_ok ? ACT_FAULT : ACT_STOP;
            end else begin
                act     = ACT_COMMIT;
                go_out  = 1'b1;
                cnt_out = cnt_in + 1'b1;
            end
        end
    end

endmodule

// File: rtl/commit_empty_track.sv
// Empty indication toward the earlier pipeline stages.
// Arms at reset or when retirement drains the buffer. Fires once the buffer
// is still empty, the store path is idle and no store committed this cycle.
// Assumes rob_occupancy is at least the retire count.
module commit_empty_track #(
    parameter int OCC_W = 6,
    parameter int RW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] rob_occupancy,
    input  logic [RW-1:0]    retire_cnt,
    input  logic             stores_pending,
    input  logic             store_committed,
    output logic             empty_ind
);

    logic             armed_q;
    logic             armed_now;
    logic [OCC_W-1:0] remaining;

    assign remaining = rob_occupancy - OCC_W'(retire_cnt);
    assign armed_now = armed_q || (retire_cnt != '0);

    // Combinational pulse, gated by the store conditions.
    always_comb begin
        empty_ind = armed_now && (remaining == '0) && !stores_pending && !store_committed;
    end

    // Arm state: kept while empty and not yet reported.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b1;
        else
            armed_q <= armed_now && (remaining == '0) && !empty_ind;
    end

    // R9
    empty_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_ind |-> (!stores_pending && !store_committed));

    // R9
    empty_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_ind |=> !armed_q);

endmodule

// File: rtl/commit_stats.sv
// Retire bandwidth counters: full-width cycles and a commits-per-cycle
// histogram. Counters wrap silently at CNT_W bits.
module commit_stats #(
    parameter int WIDTH = 4,
    parameter int CNT_W = 16,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CW-1:0]              commit_cnt,
    output logic [CNT_W-1:0]           full_cycles,
    output logic [(WIDTH+1)*CNT_W-1:0] hist
);

    // Count cycles in which the whole commit width was used.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full_cycles <= '0;
        else if (commit_cnt == CW'(WIDTH))
            full_cycles <= full_cycles + 1'b1;
    end

    for (genvar b = 0; b <= WIDTH; b++) begin : g_bin
        logic [CNT_W-1:0] bin_q;

        // One histogram bin per possible commit count.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bin_q <= '0;
            else if (commit_cnt == CW'(b))
                bin_q <= bin_q + 1'b1;
        end

        assign hist[b*CNT_W +: CNT_W] = bin_q;
    end

    // R10
    full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_cnt == CW'(WIDTH)) |=> (full_cycles == CNT_W'($past(full_cycles) + 1'b1)));

    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_cnt != CW'(WIDTH)) |=> $stable(full_cycles));

endmodule

// File: rtl/commit_retire_unit.sv
// Width-limited in-order retire stage.
// Scans WINDOW head entries each cycle through a chain of commit_slot links
// and retires up to WIDTH committed entries plus any squashed ones in
// between. It also drives the feedback to the earlier stages, the trap-hold
// state and the bandwidth counters.
// Assumes the buffer presents its oldest entries at index 0 upward and pops
// exactly retire_mask at the clock edge.
module commit_retire_unit
    import commit_retire_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int WINDOW = 8,
    parameter int SEQ_W  = 16,
    parameter int OCC_W  = 6,
    parameter int CNT_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WINDOW-1:0]          ent_valid,
    input  logic [WINDOW-1:0]          ent_ready,
    input  logic [WINDOW-1:0]          ent_executed,
    input  logic [WINDOW-1:0]          ent_squashed,
    input  logic [WINDOW-1:0]          ent_nonspec,
    input  logic [WINDOW-1:0]          ent_load,
    input  logic [WINDOW-1:0]          ent_store,
    input  logic [WINDOW-1:0]          ent_fault,
    input  logic [WINDOW*SEQ_W-1:0]    ent_seq,
    input  logic                       stores_pending,
    input  logic [OCC_W-1:0]           rob_occupancy,
    input  logic                       trap_resolve,
    output logic [WINDOW-1:0]          retire_mask,
    output logic [WINDOW-1:0]          commit_mask,
    output logic                       done_valid,
    output logic [SEQ_W-1:0]           done_seq,
    output logic                       ns_req,
    output logic                       ns_uncached,
    output logic [SEQ_W-1:0]           ns_seq,
    output logic                       trap_pending,
    output logic                       entries_changed,
    output logic                       rob_empty_ind,
    output logic [CNT_W-1:0]           full_width_cycles,
    output logic [(WIDTH+1)*CNT_W-1:0] commit_hist
);

    localparam int CW = $clog2(WIDTH + 1);
    localparam int RW = $clog2(WINDOW + 1);

    logic              go_ch  [WINDOW+1];
    logic [CW-1:0]     cnt_ch [WINDOW+1];
    slot_act_t         act    [WINDOW];
    logic              trap_q;
    logic              fault_take;
    logic              store_committed;
    logic [RW-1:0]     retire_cnt;

    assign go_ch[0]  = !trap_q;
    assign cnt_ch[0] = '0;

    for (genvar i = 0; i < WINDOW; i++) begin : g_slot
        commit_slot #(.WIDTH(WIDTH)) u_slot (
            .go_in          (go_ch[i]),
            .cnt_in         (cnt_ch[i]),
            .valid          (ent_valid[i]),
            .ready          (ent_ready[i]),
            .executed       (ent_executed[i]),
            .squashed       (ent_squashed[i]),
            .nonspec        (ent_nonspec[i]),
            .is_load        (ent_load[i]),
            .fault          (ent_fault[i]),
            .stores_pending (stores_pending),
            .go_out         (go_ch[i+1]),
            .cnt_out        (cnt_ch[i+1]),
            .act            (act[i])
        );

        assign retire_mask[i] = (act[i] == ACT_DROP) || (act[i] == ACT_COMMIT);
        assign commit_mask[i] = (act[i] == ACT_COMMIT);
    end

    // Collect per-slot actions into the feedback outputs.
    always_comb begin
        done_valid      = 1'b0;
        done_seq        = '0;
        ns_req          = 1'b0;
        ns_uncached     = 1'b0;
        ns_seq          = '0;
        fault_take      = 1'b0;
        store_committed = 1'b0;
        retire_cnt      = '0;
        for (int i = 0; i < WINDOW; i++) begin
            if (act[i] == ACT_COMMIT) begin
                done_valid = 1'b1;
                done_seq   = ent_seq[i*SEQ_W +: SEQ_W];
                if (ent_store[i])
                    store_committed = 1'b1;
            end
            if ((act[i] == ACT_NONSPEC) || (act[i] == ACT_UNCACHED)) begin
                ns_req      = 1'b1;
                ns_uncached = (act[i] == ACT_UNCACHED);
                ns_seq      = ent_seq[i*SEQ_W +: SEQ_W];
            end
            if (act[i] == ACT_FAULT)
                fault_take = 1'b1;
            retire_cnt = retire_cnt + RW'(retire_mask[i]);
        end
    end

    assign entries_changed = (retire_mask != '0);
    assign trap_pending    = trap_q;

    // Trap-hold state: set by a taken fault, cleared by the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trap_q <= 1'b0;
        else if (trap_resolve)
            trap_q <= 1'b0;
        else if (fault_take)
            trap_q <= 1'b1;
    end

    commit_empty_track #(.OCC_W(OCC_W), .RW(RW)) u_empty (
        .clk             (clk),
        .rst_n           (rst_n),
        .rob_occupancy   (rob_occupancy),
        .retire_cnt      (retire_cnt),
        .stores_pending  (stores_pending),
        .store_committed (store_committed),
        .empty_ind       (rob_empty_ind)
    );

    commit_stats #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_stats (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_cnt  (cnt_ch[WINDOW]),
        .full_cycles (full_width_cycles),
        .hist        (commit_hist)
    );

    // R1
    width_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(commit_mask) <= WIDTH);

    for (genvar i = 0; i + 1 < WINDOW; i++) begin : g_prefix_chk
        // R1
        retire_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
            retire_mask[i+1] |-> retire_mask[i]);
    end

    // R4
    ns_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ns_req |-> (!stores_pending && (commit_mask == '0)));

    // R5
    uncached_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ns_uncached |-> ns_req);

    // R6
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pending |-> (retire_mask == '0));

    // R6
    trap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_resolve |=> !trap_pending);

    // R8
    changed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entries_changed |-> (retire_mask != '0));

endmodule

// File: tb/commit_retire_unit_bench.sv
// Sweep bench: WIDTH 2, window 4, nine entry classes per slot.
module commit_retire_unit_bench;

    localparam int W   = 2;
    localparam int WIN = 4;
    localparam int SQ  = 8;
    localparam int OW  = 4;
    localparam int CN  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [WIN-1:0] ent_valid, ent_ready, ent_executed, ent_squashed;
    logic [WIN-1:0] ent_nonspec, ent_load, ent_store, ent_fault;
    logic [WIN*SQ-1:0] ent_seq;
    logic stores_pending, trap_resolve;
    logic [OW-1:0] rob_occupancy;
    logic [WIN-1:0] retire_mask, commit_mask;
    logic done_valid, ns_req, ns_uncached, trap_pending, entries_changed, rob_empty_ind;
    logic [SQ-1:0] done_seq, ns_seq;
    logic [CN-1:0] full_width_cycles;
    logic [(W+1)*CN-1:0] commit_hist;

    int n_tests = 0;
    int n_fail = 0;
    int exp_hist [W+1];
    int exp_full = 0;
    bit finished = 1'b0;

    int code [WIN];
    logic [WIN-1:0] x_ret, x_com;
    logic x_done, x_ns, x_unc, x_fault;
    logic [SQ-1:0] x_done_seq, x_ns_seq;
    int x_cnt;

    always #10 clk = ~clk;

    commit_retire_unit #(.WIDTH(W), .WINDOW(WIN), .SEQ_W(SQ), .OCC_W(OW), .CNT_W(CN)) u_commit_retire_unit (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_executed(ent_executed),
        .ent_squashed(ent_squashed), .ent_nonspec(ent_nonspec), .ent_load(ent_load),
        .ent_store(ent_store), .ent_fault(ent_fault), .ent_seq(ent_seq),
        .stores_pending(stores_pending), .rob_occupancy(rob_occupancy),
        .trap_resolve(trap_resolve),
        .retire_mask(retire_mask), .commit_mask(commit_mask),
        .done_valid(done_valid), .done_seq(done_seq),
        .ns_req(ns_req), .ns_uncached(ns_uncached), .ns_seq(ns_seq),
        .trap_pending(trap_pending), .entries_changed(entries_changed),
        .rob_empty_ind(rob_empty_ind),
        .full_width_cycles(full_width_cycles), .commit_hist(commit_hist)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Classes: 0 absent, 1 not ready, 2 squashed, 3 commit, 4 store commit,
    // 5 serialising, 6 load, 7 faulting, 8 other unexecuted.
    task automatic drive_codes(input int base);
        for (int i = 0; i < WIN; i++) begin
            ent_valid[i]    = (code[i] != 0);
            ent_ready[i]    = (code[i] != 1);
            ent_squashed[i] = (code[i] == 2);
            ent_executed[i] = (code[i] == 3) || (code[i] == 4) || (code[i] == 7);
            ent_store[i]    = (code[i] == 4);
            ent_nonspec[i]  = (code[i] == 5);
            ent_load[i]     = (code[i] == 6);
            ent_fault[i]    = (code[i] == 7);
            ent_seq[i*SQ +: SQ] = SQ'(base * 3 + i * 5);
        end
    endtask

    // Expected outcome from the requirements.
    task automatic model(input logic sp);
        bit go = 1'b1;
        x_ret = '0; x_com = '0; x_done = 0; x_ns = 0; x_unc = 0; x_fault = 0;
        x_done_seq = '0; x_ns_seq = '0; x_cnt = 0;
        for (int i = 0; i < WIN; i++) begin
            if (go) begin
                if (x_cnt == W || code[i] == 0 || code[i] == 1) go = 1'b0;
                else if (code[i] == 2) x_ret[i] = 1'b1;
                else if (code[i] == 3 || code[i] == 4) begin
                    x_ret[i] = 1'b1; x_com[i] = 1'b1; x_cnt++;
                    x_done = 1'b1; x_done_seq = ent_seq[i*SQ +: SQ];
                end else begin
                    go = 1'b0;
                    if (x_cnt == 0 && !sp) begin
                        if (code[i] == 5 || code[i] == 6) begin
                            x_ns = 1'b1; x_unc = (code[i] == 6);
                            x_ns_seq = ent_seq[i*SQ +: SQ];
                        end else if (code[i] == 7) x_fault = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic tick(input int ncommit);
        @(posedge clk);
        exp_hist[ncommit]++;
        if (ncommit == W) exp_full++;
        #1;
    endtask

    task automatic set_all(input int c);
        for (int i = 0; i < WIN; i++) code[i] = c;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        for (int b = 0; b <= W; b++) exp_hist[b] = 0;
        set_all(0); drive_codes(0);
        stores_pending = 1'b0; trap_resolve = 1'b0; rob_occupancy = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state and empty indication armed by reset.
        @(negedge clk);
        chk("R12 trap", trap_pending, 0);
        chk("R12 full", full_width_cycles, 0);
        chk("R12 hist", commit_hist, 0);
        chk("R9 armed at reset", rob_empty_ind, 1);
        tick(0);
        @(negedge clk); chk("R9 single pulse", rob_empty_ind, 0); tick(0);

        // Drain to empty with two plain commits.
        rob_occupancy = 2; set_all(0); code[0] = 3; code[1] = 3; drive_codes(1);
        @(negedge clk); chk("R9 drained", rob_empty_ind, 1); chk("R10 width", commit_mask, 4'b0011); tick(2);
        // Store committed in the draining cycle withholds it.
        code[1] = 4; drive_codes(2);
        @(negedge clk); chk("R9 store withheld", rob_empty_ind, 0); tick(2);
        rob_occupancy = 0; set_all(0); drive_codes(3);
        @(negedge clk); chk("R9 later pulse", rob_empty_ind, 1); tick(0);
        // Pending stores hold it off.
        rob_occupancy = 1; code[0] = 3; stores_pending = 1'b1; drive_codes(4);
        @(negedge clk); chk("R9 stores pending", rob_empty_ind, 0); tick(1);
        rob_occupancy = 0; set_all(0); drive_codes(5);
        @(negedge clk); chk("R9 stores still pending", rob_empty_ind, 0); tick(0);
        stores_pending = 1'b0;
        @(negedge clk); chk("R9 stores done", rob_empty_ind, 1); tick(0);
        @(negedge clk); chk("R9 disarmed", rob_empty_ind, 0); tick(0);

        // Full sweep of class patterns under both store states.
        rob_occupancy = 8;
        for (int sp = 0; sp < 2; sp++) begin
            for (int combo = 0; combo < 6561; combo++) begin
                int v = combo;
                for (int i = 0; i < WIN; i++) begin code[i] = v % 9; v = v / 9; end
                stores_pending = sp[0];
                drive_codes(combo + sp);
                model(sp[0]);
                @(negedge clk);
                chk("R1 R2 retire mask", retire_mask, x_ret);
                chk("R1 R3 commit mask", commit_mask, x_com);
                chk("R3 done valid", done_valid, x_done);
                if (x_done) chk("R3 done seq", done_seq, x_done_seq);
                chk("R4 R5 R7 ns req", ns_req, x_ns);
                chk("R5 uncached", ns_uncached, x_unc);
                if (x_ns) chk("R4 R5 ns seq", ns_seq, x_ns_seq);
                chk("R8 changed", entries_changed, (x_ret != 0));
                chk("R9 not empty", rob_empty_ind, 0);
                chk("R6 no trap", trap_pending, 0);
                tick(x_cnt);
                if (x_fault) begin
                    set_all(3); drive_codes(combo);
                    @(negedge clk);
                    chk("R6 trap set", trap_pending, 1);
                    chk("R6 held", retire_mask, 0);
                    tick(0);
                    trap_resolve = 1'b1; set_all(0); drive_codes(combo);
                    @(negedge clk); chk("R6 still held", trap_pending, 1); tick(0);
                    trap_resolve = 1'b0;
                end
            end
        end

        // Counter totals.
        @(negedge clk);
        chk("R10 full count", full_width_cycles, CN'(exp_full));
        for (int b = 0; b <= W; b++)
            chk("R11 hist bin", commit_hist[b*CN +: CN], CN'(exp_hist[b]));

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule